// File: doc/BRIEF.md
# Block Floating Point to Fixed Point Aligner

This block takes a stream of complex samples produced by a transform engine in block floating point form: each sample carries a signed real and imaginary mantissa, and each symbol carries one signed exponent. It converts them to plain fixed point so that every symbol leaving the block has its radix point in the same place, whatever exponent the transform reported.

A reference exponent is set from outside. It names the largest exponent the system expects. Every sample of a symbol is shifted arithmetically to the right by the reference minus that symbol's exponent. Mantissas already fill their full range, so the block never shifts left. Only a small set of shift amounts exists, `NUM_SHIFTS` of them (a power of two, chosen through `log2` of the count). A multiplexer picks among pre-shifted copies of the input, so the block needs no general barrel shifter. If the reference is set too low, the block clamps the shift and keeps working, but some dynamic range is lost.

Both edges of the block are valid/ready streams with start and end markers. A beat moves when valid and ready are both high at a clock edge. The input ready is the output ready, unchanged. When the consumer holds ready low, nothing is accepted and the registered output beat stays frozen. When ready is high, the output register loads whatever is offered, including an empty slot, so it needs no internal buffering.

Top module: `bfpfx_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0.
- R2: Exponents `ref_exp` and `in_exp` are EXP_W-bit two's complement. The shift amount is `ref_exp - exponent`. Real and imaginary parts are each shifted arithmetically right by it, keeping each part's own sign.
- R3: If `ref_exp - exponent` is negative, the shift is 0. The output magnitude never exceeds the input magnitude.
- R4: If `ref_exp - exponent` exceeds NUM_SHIFTS-1, the shift is NUM_SHIFTS-1 (3 by default).
- R5: The exponent is taken from the accepted beat with `in_sop`=1. It is used for that beat and for every later beat up to the next start. `in_exp` on beats without `in_sop` has no effect on the output.
- R6: A beat accepted at edge k appears on the output, with its `in_sop` and `in_eop` markers unchanged, from edge k onward (one register of latency).
- R7: `in_ready` equals `out_ready` at all times. While `out_valid`=1 and `out_ready`=0, all output fields stay stable.
- R8: At an edge where `out_ready`=1 and `in_valid`=0, `out_valid` drops to 0.
- R9: A beat with both `in_sop` and `in_eop` set forms a one-sample symbol and is scaled by its own exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_exp | input | EXP_W | Reference (largest expected) exponent, signed |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input may be accepted |
| in_re | input | DATA_W | Real mantissa, signed |
| in_im | input | DATA_W | Imaginary mantissa, signed |
| in_exp | input | EXP_W | Symbol exponent, sampled on start beats, signed |
| in_sop | input | 1 | First beat of a symbol |
| in_eop | input | 1 | Last beat of a symbol |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_re | output | DATA_W | Aligned real part |
| out_im | output | DATA_W | Aligned imaginary part |
| out_sop | output | 1 | First beat of a symbol |
| out_eop | output | 1 | Last beat of a symbol |

## Verification
Two functions can meet in one clock: taking a new exponent on a start beat, and scaling a sample that must use that same fresh exponent instead of the one held in the register. This is provoked in two ways. Single-beat symbols set start and end together. Symbols also follow one another back to back with different exponents, while the consumer's ready toggles at random. The behavioural model in the bench predicts every output beat, so using the stale exponent on a start beat, or the new exponent on the previous symbol's tail, shows up as a wrong value in that cycle's comparison.

// File: rtl/bfpfx_pkg.sv
package bfpfx_pkg;
  typedef struct packed {
    logic sop;
    logic eop;
  } bfpfx_mark_t;

  function automatic int bfpfx_top_shift(input int n_sel);
    return n_sel - 1;
  endfunction
endpackage

// File: rtl/bfpfx_exp_track.sv
module bfpfx_exp_track #(
  parameter int EXP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sop,
  input  logic [EXP_W-1:0] exp_in,
  output logic [EXP_W-1:0] exp_eff
);
  logic [EXP_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (take && sop) held_q <= exp_in;
  end

  // a start beat uses its own exponent in the same cycle
  assign exp_eff = sop ? exp_in : held_q;
endmodule

// File: rtl/bfpfx_shift_sel.sv
module bfpfx_shift_sel #(
  parameter int EXP_W = 6,
  parameter int SH_W  = 2
) (
  input  logic [EXP_W-1:0] ref_exp,
  input  logic [EXP_W-1:0] blk_exp,
  output logic [SH_W-1:0]  amount
);
  localparam int DW   = EXP_W + 1;
  localparam int TOPS = bfpfx_pkg::bfpfx_top_shift(1 << SH_W);
  localparam logic signed [DW-1:0] TOPV = DW'(TOPS);

  logic signed [DW-1:0] diff;

  always_comb begin
    diff = $signed({ref_exp[EXP_W-1], ref_exp}) - $signed({blk_exp[EXP_W-1], blk_exp});
    if (diff < 0)         amount = '0;
    else if (diff > TOPV) amount = SH_W'(TOPS);
    else                  amount = diff[SH_W-1:0];
  end
endmodule

// File: rtl/bfpfx_mux_shift.sv
module bfpfx_mux_shift #(
  parameter int W    = 16,
  parameter int SH_W = 2
) (
  input  logic signed [W-1:0] din,
  input  logic [SH_W-1:0]     sel,
  output logic signed [W-1:0] dout
);
  localparam int NSEL = 1 << SH_W;

  logic signed [W-1:0] cand [NSEL];

  generate
    for (genvar k = 0; k < NSEL; k++) begin : g_tap
      assign cand[k] = din >>> k;
    end
  endgenerate

  assign dout = cand[sel];
endmodule

// File: rtl/bfpfx_top.sv
module bfpfx_top #(
  parameter int DATA_W     = 16,
  parameter int EXP_W      = 6,
  parameter int NUM_SHIFTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXP_W-1:0]  ref_exp,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im,
  output logic              out_sop,
  output logic              out_eop
);
  import bfpfx_pkg::*;

  localparam int SH_W = $clog2(NUM_SHIFTS);

  logic                     accept;
  logic [EXP_W-1:0]         exp_eff;
  logic [SH_W-1:0]          amount;
  logic signed [DATA_W-1:0] re_sh;
  logic signed [DATA_W-1:0] im_sh;
  logic [DATA_W-1:0]        re_q;
  logic [DATA_W-1:0]        im_q;
  bfpfx_mark_t              mark_q;
  logic                     vld_q;

  assign in_ready = out_ready;
  assign accept   = in_valid && out_ready;

  bfpfx_exp_track #(.EXP_W(EXP_W)) u_exp (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (accept),
    .sop    (in_sop),
    .exp_in (in_exp),
    .exp_eff(exp_eff)
  );

  bfpfx_shift_sel #(.EXP_W(EXP_W), .SH_W(SH_W)) u_sel (
    .ref_exp(ref_exp),
    .blk_exp(exp_eff),
    .amount (amount)
  );

  bfpfx_mux_shift #(.W(DATA_W), .SH_W(SH_W)) u_re (
    .din (signed'(in_re)),
    .sel (amount),
    .dout(re_sh)
  );

  bfpfx_mux_shift #(.W(DATA_W), .SH_W(SH_W)) u_im (
    .din (signed'(in_im)),
    .sel (amount),
    .dout(im_sh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      re_q   <= '0;
      im_q   <= '0;
      mark_q <= '0;
    end else if (out_ready) begin
      vld_q <= in_valid;
      if (in_valid) begin
        re_q       <= re_sh;
        im_q       <= im_sh;
        mark_q.sop <= in_sop;
        mark_q.eop <= in_eop;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_re    = re_q;
  assign out_im    = im_q;
  assign out_sop   = mark_q.sop;
  assign out_eop   = mark_q.eop;
endmodule

// File: rtl/bfpfx_checker.sv
module bfpfx_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_re,
  input logic [DATA_W-1:0] in_im,
  input logic              in_sop,
  input logic              in_eop,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_re,
  input logic [DATA_W-1:0] out_im,
  input logic              out_sop,
  input logic              out_eop
);
  always @(posedge clk) begin
    if (!rst_n) a_r1_idle_in_reset: assert (out_valid == 1'b0);
  end

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r6_markers: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_sop == $past(in_sop)) && (out_eop == $past(in_eop)));

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_re) && $stable(out_im)
                                  && $stable(out_sop) && $stable(out_eop));

  a_r2_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_re[DATA_W-1] == $past(in_re[DATA_W-1]))
                               && (out_im[DATA_W-1] == $past(in_im[DATA_W-1])));

  a_r3_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_re[DATA_W-1]) |=> (out_re <= $past(in_re)));
endmodule

bind bfpfx_top bfpfx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_re    (in_re),
  .in_im    (in_im),
  .in_sop   (in_sop),
  .in_eop   (in_eop),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_re   (out_re),
  .out_im   (out_im),
  .out_sop  (out_sop),
  .out_eop  (out_eop)
);

// File: tb/sim_bfpfx_top.sv
module sim_bfpfx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ref_exp = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_re = '0;
  logic [15:0] in_im = '0;
  logic [5:0]  in_exp = '0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_re;
  logic [15:0] out_im;
  logic        out_sop;
  logic        out_eop;

  always #10 clk = ~clk;

  bfpfx_top u0 (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  bit    m_valid = 0, m_sop = 0, m_eop = 0;
  int    m_re = 0, m_im = 0, m_exp = 0;
  string m_tag = "R2";

  // stimulus state
  int unsigned rng = 32'h1234_5677;
  int sym = 0, beat = 0, len = 1, cur_ref = 0, cur_exp = 0;

  function automatic int unsigned next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic load_beat();
    if (beat == 0) begin
      case (sym)
        0: begin cur_ref = 5;  cur_exp = 3; len = 4; end  // plain shift by 2
        1: begin cur_ref = 2;  cur_exp = 7; len = 3; end  // negative difference
        2: begin cur_ref = 10; cur_exp = 0; len = 3; end  // clamp to 3
        3: begin cur_ref = 6;  cur_exp = 5; len = 1; end  // single-beat symbol
        default: begin
          cur_ref = int'(next_rand() % 13);
          cur_exp = int'(next_rand() % 17) - 4;
          len     = 1 + int'(next_rand() % 4);
        end
      endcase
    end
    ref_exp = 6'(cur_ref);
    in_sop  = (beat == 0);
    in_eop  = (beat == len - 1);
    in_exp  = (beat == 0) ? 6'(cur_exp) : 6'(next_rand());
    in_re   = 16'(next_rand());
    in_im   = 16'(next_rand());
  endtask

  // model of the edge that has just passed, from the inputs present at it
  task automatic model_step(input bit acc);
    if (out_ready) begin
      m_valid = in_valid;
      if (in_valid) begin
        int e, d, sh;
        e = in_sop ? int'($signed(in_exp)) : m_exp;
        d = int'($signed(ref_exp)) - e;
        sh = (d < 0) ? 0 : ((d > 3) ? 3 : d);
        if (in_sop && in_eop)                               m_tag = "R9";
        else if (!in_sop && int'($signed(in_exp)) != m_exp) m_tag = "R5";
        else if (d < 0)                                     m_tag = "R3";
        else if (d > 3)                                     m_tag = "R4";
        else                                                m_tag = "R2";
        m_re  = int'($signed(in_re)) >>> sh;
        m_im  = int'($signed(in_im)) >>> sh;
        m_sop = in_sop;
        m_eop = in_eop;
        if (acc && in_sop) m_exp = int'($signed(in_exp));
      end
    end
  endtask

  task automatic compare();
    check(out_valid == m_valid, m_valid ? "R6" : "R8", "out_valid",
          int'(out_valid), int'(m_valid));
    if (m_valid) begin
      check(int'($signed(out_re)) == m_re, m_tag, "out_re", int'($signed(out_re)), m_re);
      check(int'($signed(out_im)) == m_im, m_tag, "out_im", int'($signed(out_im)), m_im);
      check(out_sop == m_sop && out_eop == m_eop, "R6", "markers",
            int'({out_sop, out_eop}), int'({m_sop, m_eop}));
    end
  endtask

  task automatic cycle(input bit random_hs, input bit feed);
    bit acc;
    @(negedge clk);
    acc = in_valid && out_ready;
    model_step(acc);
    compare();
    if (acc) begin
      beat++;
      if (beat == len) begin beat = 0; sym++; end
      load_beat();
    end
    if (!feed) begin
      in_valid  = 1'b0;
      out_ready = 1'b1;
    end else if (random_hs) begin
      in_valid  = (next_rand() % 4) != 0;
      out_ready = (next_rand() % 4) != 0;
    end else begin
      in_valid  = 1'b1;
      out_ready = 1'b1;
    end
    #1;
    check(in_ready == out_ready, "R7", "in_ready", int'(in_ready), int'(out_ready));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    load_beat();
    in_valid = 1'b1;
    while (sym < 4)   cycle(1'b0, 1'b1);
    while (sym < 150) cycle(1'b1, 1'b1);
    repeat (4) cycle(1'b0, 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule